// File: doc/BRIEF.md
# Half-Precision Pair to Single-Precision Unpacker

This unit accepts one 32-bit word that carries two IEEE half-precision numbers and returns both as IEEE single-precision bit patterns. The half in bits 15:0 drives the low result and the half in bits 31:16 drives the high result. Each lane classifies its half as zero, subnormal, normal, infinity or NaN and assembles the wider pattern directly. Every half value has an exact single-precision equivalent, so no rounding logic is present.

A word is taken when the input valid strobe is high. Both results appear in a register one clock later together with an output valid strobe. When no word is offered, the register keeps its previous contents. Reset is asserted asynchronously and released through a two-stage synchronizer. Reset clears the valid flag and both results.

Top module: `half_pair_unpack`

## Requirements
- R1: Input bits 15:0 produce `out_lo` and input bits 31:16 produce `out_hi`; each half has its sign at bit 15, exponent at bits 14:10 and mantissa at bits 9:0.
- R2: A half with exponent 0 and mantissa 0 gives magnitude 0x00000000.
- R3: A half with exponent 0 and nonzero mantissa m gives the exact value m×2^-24: exponent field = p+103 where p is the index of the highest set mantissa bit, and mantissa field = the mantissa bits below p, left-aligned into bits 22:0.
- R4: A half with exponent e in 1..30 gives exponent field e+112 (bits 30:23) and mantissa field equal to the half mantissa shifted left by 13.
- R5: A half with exponent 31 and mantissa 0 gives magnitude 0x7F800000.
- R6: A half with exponent 31 and nonzero mantissa gives magnitude 0x7FFFFFFF, whatever the payload.
- R7: The half sign (bit 15) is copied to result bit 31 in every class, so a negative NaN gives 0xFFFFFFFF and a negative zero gives 0x80000000.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and both results for that word are presented in that same cycle.
- R9: In a cycle following one with `in_valid` low, `out_lo` and `out_hi` keep their previous values.
- R10: While `rst_n` is low, `out_valid`, `out_lo` and `out_hi` are 0, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 32 | Two halves, low lane in bits 15:0 |
| out_valid | output | 1 | Results are valid this cycle |
| out_lo | output | 32 | Single-precision form of bits 15:0 |
| out_hi | output | 32 | Single-precision form of bits 31:16 |

## Verification
Every one of the 65536 half encodings passes through each lane once, so a bad class decision or a wrong leading-one position shows as a wrong bit pattern in the cycle after that code enters. An error in the exponent offset or the mantissa alignment would only affect certain codes. The full sweep covers all of them. If the enable or the valid register were wrong, the results would arrive in the wrong cycle or would drift during idle gaps. This shows within one clock, because every result is tagged with the cycle in which it should appear.

// File: rtl/hpu_pkg.sv
package hpu_pkg;
  localparam int H_W      = 16;
  localparam int H_EXP_W  = 5;
  localparam int H_MAN_W  = 10;
  localparam int H_BIAS   = 15;
  localparam int S_W      = 32;
  localparam int S_EXP_W  = 8;
  localparam int S_MAN_W  = 23;
  localparam int S_BIAS   = 127;
  localparam int LANES    = 2;
  localparam int IN_W     = LANES * H_W;
  localparam int EXP_ADJ  = S_BIAS - H_BIAS;
  localparam int SUB_BASE = S_BIAS - (H_BIAS - 1) - H_MAN_W;
  localparam int POS_W    = $clog2(H_MAN_W);
  localparam logic [H_EXP_W-1:0] H_EXP_MAX = '1;
  localparam logic [S_W-2:0] S_INF_MAG = {{S_EXP_W{1'b1}}, {S_MAN_W{1'b0}}};
  localparam logic [S_W-2:0] S_NAN_MAG = '1;

  typedef enum logic [2:0] {
    HC_ZERO,
    HC_SUB,
    HC_NORM,
    HC_INF,
    HC_NAN
  } half_class_e;

  typedef logic [S_W-1:0] single_t;
endpackage

// File: rtl/hpu_rst_sync.sv
module hpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hpu_lead_one.sv
module hpu_lead_one #(
  parameter int W  = 10,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int k = 0; k < W; k++) begin
      if (vec[k]) pos = PW'(k);
    end
  end
endmodule

// File: rtl/hpu_lane.sv
module hpu_lane
  import hpu_pkg::*;
(
  input  logic [H_W-1:0] half_i,
  output single_t        single_o
);
  logic                 sgn;
  logic [H_EXP_W-1:0]   hexp;
  logic [H_MAN_W-1:0]   hman;
  logic [POS_W-1:0]     lead_pos;
  half_class_e          cls;
  logic [S_MAN_W:0]     sub_wide;
  logic [S_EXP_W-1:0]   sub_exp;
  logic [S_EXP_W-1:0]   norm_exp;
  logic [S_W-2:0]       mag;

  assign sgn  = half_i[H_W-1];
  assign hexp = half_i[H_W-2 -: H_EXP_W];
  assign hman = half_i[H_MAN_W-1:0];

  hpu_lead_one #(.W(H_MAN_W), .PW(POS_W)) u_lod (
    .vec (hman),
    .pos (lead_pos)
  );

  always_comb begin
    if (hexp == '0)            cls = (hman == '0) ? HC_ZERO : HC_SUB;
    else if (hexp == H_EXP_MAX) cls = (hman == '0) ? HC_INF : HC_NAN;
    else                       cls = HC_NORM;
  end

  always_comb begin
    sub_wide = {{(S_MAN_W + 1 - H_MAN_W){1'b0}}, hman} << (S_MAN_W - int'(lead_pos));
    sub_exp  = S_EXP_W'(lead_pos) + S_EXP_W'(SUB_BASE);
    norm_exp = S_EXP_W'(hexp) + S_EXP_W'(EXP_ADJ);
  end

  always_comb begin
    unique case (cls)
      HC_ZERO: mag = '0;
      HC_SUB:  mag = {sub_exp, sub_wide[S_MAN_W-1:0]};
      HC_NORM: mag = {norm_exp, hman, {(S_MAN_W - H_MAN_W){1'b0}}};
      HC_INF:  mag = S_INF_MAG;
      default: mag = S_NAN_MAG;
    endcase
    single_o = {1'b0, mag} | (S_W'(sgn) << (S_W - 1));
  end
endmodule

// File: rtl/half_pair_unpack.sv
module half_pair_unpack
  import hpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_lo,
  output logic [31:0] out_hi
);
  logic    rst_sync_n;
  single_t lane_res [LANES];
  logic    valid_d, valid_q;
  single_t lo_d, lo_q, hi_d, hi_q;

  hpu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hpu_lane u_lane (
      .half_i   (in_word[g*H_W +: H_W]),
      .single_o (lane_res[g])
    );
  end

  always_comb begin
    valid_d = in_valid;
    lo_d    = in_valid ? lane_res[0] : lo_q;
    hi_d    = in_valid ? lane_res[1] : hi_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      valid_q <= valid_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign out_valid = valid_q;
  assign out_lo    = lo_q;
  assign out_hi    = hi_q;
endmodule

// File: rtl/half_pair_unpack_chk.sv
module half_pair_unpack_chk (
  input logic        clk,
  input logic        rst_ni,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [31:0] out_lo,
  input logic [31:0] out_hi
);
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid == $past(in_valid));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> ($stable(out_lo) && $stable(out_hi)));

  assert_sign_copy_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> (out_lo[31] == $past(in_word[15]) && out_hi[31] == $past(in_word[31])));

  assert_nan_low_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_word[14:10] == 5'h1F && in_word[9:0] != 10'h0)
      |=> out_lo[30:0] == 31'h7FFFFFFF);

  assert_inf_high_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_word[30:16] == 15'h7C00) |=> out_hi[30:0] == 31'h7F800000);

  always_ff @(posedge clk) begin
    if (!rst_ni) assert_reset_clear_R10: assert (!out_valid);
  end
endmodule

bind half_pair_unpack half_pair_unpack_chk u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_lo    (out_lo),
  .out_hi    (out_hi)
);

// File: tb/half_pair_unpack_tb.sv
module half_pair_unpack_tb;
  localparam int LIMIT = 200000;

  typedef struct {
    logic [31:0] lo, hi;
    logic [15:0] hlo, hhi;
    int          due;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [31:0] out_lo, out_hi;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  bit    have_last = 0;
  logic [31:0] last_lo, last_hi;
  item_t q[$];

  always #5 clk = ~clk;

  half_pair_unpack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
  );

  function automatic logic [31:0] ref_single(input logic [15:0] h);
    logic [4:0]  e;
    logic [10:0] mm;
    int          ex;
    logic [30:0] mag;
    e = h[14:10];
    mm = {1'b0, h[9:0]};
    if (e == 0 && mm == 0) mag = 31'h0;
    else if (e == 0) begin
      ex = 113;
      while (mm[10] == 1'b0) begin
        mm = mm << 1;
        ex = ex - 1;
      end
      mag = {8'(ex), mm[9:0], 13'h0};
    end else if (e == 5'd31) mag = (h[9:0] == 0) ? 31'h7F800000 : 31'h7FFFFFFF;
    else mag = {8'(int'(e) + 112), h[9:0], 13'h0};
    return {h[15], mag};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R2" : "R3";
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R5" : "R6";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      finish_up();
    end
  end

  task automatic send(input logic [15:0] lo, input logic [15:0] hi);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = {hi, lo};
    it.hlo = lo; it.hhi = hi;
    it.lo = ref_single(lo); it.hi = ref_single(hi);
    it.due = cyc + 1;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected items when results appear, checks hold when idle.
  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      have_last = 0;
    end else if (out_valid) begin
      if (q.size() == 0) begin
        check("R8 unexpected out_valid", {31'h0, out_valid}, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        check("R8 latency", cyc, it.due);
        check({tag_of(it.hlo), " R7 low lane"}, out_lo, it.lo);
        check({tag_of(it.hhi), " R1 high lane"}, out_hi, it.hi);
        last_lo = it.lo; last_hi = it.hi; have_last = 1;
      end
    end else if (have_last) begin
      check("R9 hold low", out_lo, last_lo);
      check("R9 hold high", out_hi, last_hi);
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 valid in reset", {31'h0, out_valid}, 32'h0);
    check("R10 lo in reset", out_lo, 32'h0);
    check("R10 hi in reset", out_hi, 32'h0);
    rst_n = 1'b1;
    idle(4);
    check("R10 valid after release", {31'h0, out_valid}, 32'h0);

    // Directed corners, swapped across lanes for R1
    send(16'h0000, 16'h8000);   // R2 zero, R7 negative zero
    send(16'h0001, 16'h03FF);   // R3 smallest and largest subnormal
    send(16'h8200, 16'h0400);   // R3 negative, R4 smallest normal
    send(16'h7BFF, 16'h3C00);   // R4 largest normal, one
    send(16'h7C00, 16'hFC00);   // R5 infinities
    send(16'h7E00, 16'hFC01);   // R6 NaN, R7 negative NaN
    send(16'h3C00, 16'h0001);   // R1 lane separation
    idle(3);

    // Exhaustive sweep of both lanes with idle gaps
    for (int i = 0; i < 65536; i++) begin
      send(16'(i), 16'((i * 40503 + 12345) & 16'hFFFF));
      if ((i % 4096) == 4095) idle(2);
    end
    idle(4);
    check("R8 queue drained", q.size(), 0);

    // R10: asynchronous clear of a live result
    send(16'h3C00, 16'h3C00);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R10 async valid", {31'h0, out_valid}, 32'h0);
    check("R10 async lo", out_lo, 32'h0);
    check("R10 async hi", out_hi, 32'h0);
    in_valid = 1'b0;
    idle(2);
    finish_up();
  end
endmodule